// File: doc/BRIEF.md
# SM4 Four-Round Group Cipher Engine

This block applies four chained SM4 encryption rounds to each 128-bit element group of a vector operand. A command sets the element width, the start element index, the vector length and two register indices, and picks the key mode. The engine then accepts one state group per cycle on a valid/ready input stream. Each state group returns on a valid/ready output stream, transformed and tagged with its group index, so the caller can write it back in place.

A state group holds four little-endian 32-bit words x0..x3, with x0 in bits 31:0. A key group holds rk0..rk3 in the same layout. Round i forms x(i+4) = x(i) ^ L(tau(x(i+1) ^ x(i+2) ^ x(i+3) ^ rk(i))). In this formula, tau replaces every byte through the SM4 substitution: the multiplicative inverse in GF(2^8) modulo x^8+x^7+x^6+x^5+x^4+x^2+1, with the same affine map (row 0xE5 rotated right once per row, constant 0xD3) applied before and after it. L(S) is S ^ rotl(S,2) ^ rotl(S,10) ^ rotl(S,18) ^ rotl(S,24). The result is {x7,x6,x5,x4}, with x4 in the lowest word. Eight passes with successive round-key groups make up a full 32-round encryption. Reversing the final word order is left to the caller.

Back-pressure follows the usual stream rules. An input beat transfers on a clock edge where `in_valid` and `in_ready` are both high, and an output beat on an edge where `out_valid` and `out_ready` are both high. The output holds one beat. `in_ready` is high only while the engine still expects groups and the output slot is empty or is being emptied in that same cycle. Once `out_valid` is raised, the output beat stays unchanged until it is taken.

Top module: `sm4r_core`

## Requirements
- R1: Each output beat equals four chained SM4 rounds applied to the accepted state group, with the word layout, the S-box and L as defined above. The result is {x7,x6,x5,x4}, with x4 in bits 31:0.
- R2: In per-group mode (`cmd_scalar`=0), each state group is transformed with the `in_key` value that arrives in the same input beat.
- R3: In scalar mode (`cmd_scalar`=1), every group uses the `cmd_key` value captured at the accepted command. `in_key` has no effect, and neither do later changes of `cmd_key`.
- R4: A command is illegal unless `cmd_sew` is 3'b010 (32-bit elements) and `cmd_vstart` and `cmd_vl` are both multiples of 4. For an illegal command, `illegal` pulses for one cycle in the cycle after `cmd_start`, and the engine stays idle.
- R5: In scalar mode, a command whose `cmd_dst_reg` equals `cmd_key_reg` is illegal. In per-group mode, equal indices are allowed.
- R6: A legal command accepts exactly (vl-vstart)/4 groups. They are tagged in order on `out_group`, from vstart/4 up to vl/4-1.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_state` and `out_group` hold. `in_ready` is low whenever the output slot stays full, and also whenever the engine expects no more groups.
- R8: `done` pulses for one cycle in the cycle after the last output beat transfers, and `busy` is low in that cycle. A legal command with vstart >= vl produces no output beat, and `done` pulses in the cycle after `cmd_start`.
- R9: `cmd_start` is ignored while `busy` is high.
- R10: An accepted input beat appears on the output in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_start | input | 1 | Command strobe, sampled while idle |
| cmd_scalar | input | 1 | 1 = one key group for all groups, 0 = per-group key |
| cmd_sew | input | 3 | Element width code, 3'b010 = 32 bits |
| cmd_vstart | input | IDX_W | Start element index |
| cmd_vl | input | IDX_W | Vector length in elements |
| cmd_dst_reg | input | REG_W | Destination register index |
| cmd_key_reg | input | REG_W | Key register index |
| cmd_key | input | 128 | Key group 0 for scalar mode |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle rejection pulse |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted this cycle |
| in_state | input | 128 | State group |
| in_key | input | 128 | Key group (per-group mode) |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer takes the output beat |
| out_state | output | 128 | Transformed state group |
| out_group | output | IDX_W-2 | Index of the group in `out_state` |

## Verification
The bench sweeps every start index from 0 to 7 against lengths from 0 to 12 in both key modes. This covers unaligned starts, unaligned lengths and empty ranges. A checker that ignored one of the alignment bits would start a run where the bench expects a rejection pulse, and an off-by-one in the group counter would emit a wrong tag or one beat too many or too few. Scalar runs put random data on `in_key` and change `cmd_key` in mid-run, so a key multiplexer that leaked either value would corrupt every result. Runs with a stalling consumer catch an output register that gets overwritten under back-pressure. A second `cmd_start` injected during a run catches a sequencer that re-arms while busy. The longest legal range, 63 groups, exercises the top of the index counter.

// File: rtl/sm4r_pkg.sv
package sm4r_pkg;
  typedef logic [31:0]  word_t;
  typedef logic [127:0] grp_t;

  localparam logic [2:0] SEW_32    = 3'b010;
  localparam logic [7:0] GF_RED    = 8'hF5;  // low byte of x^8+x^7+x^6+x^5+x^4+x^2+1
  localparam logic [7:0] AFF_ROW   = 8'hE5;
  localparam logic [7:0] AFF_CONST = 8'hD3;

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[7] ? ({sh[6:0], 1'b0} ^ GF_RED) : {sh[6:0], 1'b0};
    end
    return acc;
  endfunction

  // a^254 by square-and-multiply: a^3, a^7, ... a^127, then square
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] t;
    t = a;
    for (int i = 0; i < 6; i++) t = gf_mul(gf_mul(t, t), a);
    return gf_mul(t, t);
  endfunction

  function automatic logic [7:0] ror8(input logic [7:0] v, input int n);
    logic [15:0] d;
    d = {v, v} >> n;
    return d[7:0];
  endfunction

  function automatic logic [7:0] affine(input logic [7:0] x);
    logic [7:0] y;
    for (int r = 0; r < 8; r++) y[7-r] = ^(ror8(AFF_ROW, r) & x);
    return y ^ AFF_CONST;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] b);
    return affine(gf_inv(affine(b)));
  endfunction

  function automatic word_t rotl(input word_t w, input int n);
    logic [63:0] d;
    d = {w, w} << n;
    return d[63:32];
  endfunction

  function automatic word_t lin(input word_t s);
    return s ^ rotl(s, 2) ^ rotl(s, 10) ^ rotl(s, 18) ^ rotl(s, 24);
  endfunction
endpackage

// File: rtl/sm4r_round.sv
module sm4r_round
  import sm4r_pkg::*;
(
  input  word_t x0,
  input  word_t x1,
  input  word_t x2,
  input  word_t x3,
  input  word_t rk,
  output word_t xn
);
  localparam int LANES = $bits(word_t) / 8;

  word_t mix;
  word_t sub;

  assign mix = x1 ^ x2 ^ x3 ^ rk;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign sub[8*b +: 8] = sbox(mix[8*b +: 8]);
  end

  assign xn = x0 ^ lin(sub);
endmodule

// File: rtl/sm4r_quad.sv
module sm4r_quad
  import sm4r_pkg::*;
#(
  parameter int ROUNDS = 4
) (
  input  grp_t st,
  input  grp_t key,
  output grp_t res
);
  localparam int WORDS = $bits(grp_t) / $bits(word_t);
  localparam int WW    = $bits(word_t);

  word_t w [WORDS + ROUNDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_in
    assign w[i] = st[WW*i +: WW];
  end

  for (genvar i = 0; i < ROUNDS; i++) begin : g_rnd
    sm4r_round u_rnd (
      .x0 (w[i]),
      .x1 (w[i+1]),
      .x2 (w[i+2]),
      .x3 (w[i+3]),
      .rk (key[WW*(i % WORDS) +: WW]),
      .xn (w[i+4])
    );
  end

  for (genvar i = 0; i < WORDS; i++) begin : g_out
    assign res[WW*i +: WW] = w[ROUNDS + i];
  end
endmodule

// File: rtl/sm4r_seq.sv
module sm4r_seq
  import sm4r_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int REG_W = 5,
  localparam int GRP_W = IDX_W - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             scalar,
  input  logic [2:0]       sew,
  input  logic [IDX_W-1:0] vstart,
  input  logic [IDX_W-1:0] vl,
  input  logic [REG_W-1:0] dst_reg,
  input  logic [REG_W-1:0] key_reg,
  input  logic             in_fire,
  input  logic             out_fire,
  output logic             arm,
  output logic             scalar_q,
  output logic             feeding,
  output logic             busy,
  output logic [GRP_W-1:0] grp_idx,
  output logic             done,
  output logic             illegal
);
  typedef enum logic [1:0] {S_IDLE, S_FEED, S_DRAIN} st_e;

  st_e              st_q;
  logic [GRP_W-1:0] end_q;
  logic             legal;
  logic             empty;
  logic [GRP_W-1:0] grp_nxt;

  assign arm   = start && (st_q == S_IDLE);
  assign legal = (sew == SEW_32) && (vstart[1:0] == 2'b00) && (vl[1:0] == 2'b00)
               && !(scalar && (dst_reg == key_reg));
  assign empty = (vstart >= vl);
  assign grp_nxt = grp_idx + 1'b1;

  assign feeding = (st_q == S_FEED);
  assign busy    = (st_q != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      end_q    <= '0;
      grp_idx  <= '0;
      scalar_q <= 1'b0;
      done     <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      unique case (st_q)
        S_IDLE: if (arm) begin
          if (!legal) begin
            illegal <= 1'b1;
          end else if (empty) begin
            done <= 1'b1;
          end else begin
            st_q     <= S_FEED;
            grp_idx  <= vstart[IDX_W-1:2];
            end_q    <= vl[IDX_W-1:2];
            scalar_q <= scalar;
          end
        end
        S_FEED: if (in_fire) begin
          grp_idx <= grp_nxt;
          if (grp_nxt == end_q) st_q <= S_DRAIN;
        end
        S_DRAIN: if (out_fire) begin
          st_q <= S_IDLE;
          done <= 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sm4r_core.sv
module sm4r_core
  import sm4r_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int REG_W = 5,
  localparam int GRP_W = IDX_W - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic             cmd_scalar,
  input  logic [2:0]       cmd_sew,
  input  logic [IDX_W-1:0] cmd_vstart,
  input  logic [IDX_W-1:0] cmd_vl,
  input  logic [REG_W-1:0] cmd_dst_reg,
  input  logic [REG_W-1:0] cmd_key_reg,
  input  logic [127:0]     cmd_key,
  output logic             busy,
  output logic             done,
  output logic             illegal,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [127:0]     in_state,
  input  logic [127:0]     in_key,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [127:0]     out_state,
  output logic [GRP_W-1:0] out_group
);
  logic             arm;
  logic             scalar_q;
  logic             feeding;
  logic [GRP_W-1:0] grp_idx;
  logic             in_fire;
  logic             out_fire;
  grp_t             skey_q;
  grp_t             key_sel;
  grp_t             res;

  sm4r_seq #(.IDX_W(IDX_W), .REG_W(REG_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (cmd_start),
    .scalar   (cmd_scalar),
    .sew      (cmd_sew),
    .vstart   (cmd_vstart),
    .vl       (cmd_vl),
    .dst_reg  (cmd_dst_reg),
    .key_reg  (cmd_key_reg),
    .in_fire  (in_fire),
    .out_fire (out_fire),
    .arm      (arm),
    .scalar_q (scalar_q),
    .feeding  (feeding),
    .busy     (busy),
    .grp_idx  (grp_idx),
    .done     (done),
    .illegal  (illegal)
  );

  assign in_ready = feeding && (!out_valid || out_ready);
  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;
  assign key_sel  = scalar_q ? skey_q : in_key;

  sm4r_quad u_quad (
    .st  (in_state),
    .key (key_sel),
    .res (res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) skey_q <= '0;
    else if (arm) skey_q <= cmd_key;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_state <= '0;
      out_group <= '0;
    end else if (in_fire) begin
      out_valid <= 1'b1;
      out_state <= res;
      out_group <= grp_idx;
    end else if (out_fire) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sm4r_core_chk.sv
module sm4r_core_chk #(
  parameter int IDX_W = 8,
  localparam int GRP_W = IDX_W - 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             illegal,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [127:0]     out_state,
  input logic [GRP_W-1:0] out_group
);
  AST_ILLEGAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n) illegal |-> !busy); // R4
  AST_DONE_NOT_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n) !(done && illegal)); // R4
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_state) && $stable(out_group))); // R7
  AST_IDLE_NO_READY: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !in_ready); // R7
  AST_READY_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!out_valid || out_ready)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && !out_valid)); // R8
  AST_FIRE_TO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R10
endmodule

bind sm4r_core sm4r_core_chk #(.IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .illegal   (illegal),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_state (out_state),
  .out_group (out_group)
);

// File: tb/sm4r_core_tb_top.sv
module sm4r_core_tb_top;
  localparam int IDX_W = 8;
  localparam int REG_W = 5;
  localparam int GRP_W = IDX_W - 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_start = 1'b0;
  logic             cmd_scalar = 1'b0;
  logic [2:0]       cmd_sew = 3'b010;
  logic [IDX_W-1:0] cmd_vstart = '0;
  logic [IDX_W-1:0] cmd_vl = '0;
  logic [REG_W-1:0] cmd_dst_reg = '0;
  logic [REG_W-1:0] cmd_key_reg = '0;
  logic [127:0]     cmd_key = '0;
  logic             busy, done, illegal;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [127:0]     in_state = '0;
  logic [127:0]     in_key = '0;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic [127:0]     out_state;
  logic [GRP_W-1:0] out_group;

  int tests = 0;
  int fails = 0;
  logic [7:0] sb_tab [256];

  always #4 clk = ~clk;

  sm4r_core #(.IDX_W(IDX_W), .REG_W(REG_W)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // carry-less product, then reduction by 0x1F5
  function automatic logic [7:0] b_mul(input logic [7:0] a, input logic [7:0] b);
    logic [14:0] p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (15'(a) << i);
    for (int k = 14; k >= 8; k--) if (p[k]) p = p ^ (15'h1F5 << (k - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] b_inv(input logic [7:0] a);
    if (a == 8'h00) return 8'h00;
    for (int y = 1; y < 256; y++) if (b_mul(a, 8'(y)) == 8'h01) return 8'(y);
    return 8'h00;
  endfunction

  function automatic logic [7:0] b_aff(input logic [7:0] x);
    logic [7:0] y;
    for (int j = 0; j < 8; j++)
      y[j] = x[j] ^ x[(j+1)%8] ^ x[(j+3)%8] ^ x[(j+6)%8] ^ x[(j+7)%8];
    return y ^ 8'hD3;
  endfunction

  function automatic logic [31:0] b_rl(input logic [31:0] v, input int n);
    return (v << n) | (v >> (32 - n));
  endfunction

  function automatic logic [31:0] b_tl(input logic [31:0] b);
    logic [31:0] s;
    s = {sb_tab[b[31:24]], sb_tab[b[23:16]], sb_tab[b[15:8]], sb_tab[b[7:0]]};
    return s ^ b_rl(s, 2) ^ b_rl(s, 10) ^ b_rl(s, 18) ^ b_rl(s, 24);
  endfunction

  function automatic logic [127:0] b_quad(input logic [127:0] st, input logic [127:0] k);
    logic [31:0] x [8];
    for (int i = 0; i < 4; i++) x[i] = st[32*i +: 32];
    for (int i = 0; i < 4; i++) x[i+4] = x[i] ^ b_tl(x[i+1] ^ x[i+2] ^ x[i+3] ^ k[32*i +: 32]);
    return {x[7], x[6], x[5], x[4]};
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic run_cmd(input bit scalar, input logic [2:0] sew, input int vs, input int vl,
                         input int dst, input int kr, input bit stall, input bit poke);
    bit legal;
    int n, sent, rcvd, cyc, eg;
    logic [127:0] ckey, st, kg, held;
    logic [127:0] expq [$];
    int grpq [$];
    bit acc_prev, held_prev;
    legal = (sew == 3'b010) && (vs % 4 == 0) && (vl % 4 == 0) && !(scalar && dst == kr);
    ckey = rnd128();
    @(negedge clk);
    cmd_start = 1'b1; cmd_scalar = scalar; cmd_sew = sew;
    cmd_vstart = IDX_W'(vs); cmd_vl = IDX_W'(vl);
    cmd_dst_reg = REG_W'(dst); cmd_key_reg = REG_W'(kr); cmd_key = ckey;
    @(negedge clk);
    cmd_start = 1'b0;
    if (!legal) begin
      chk(illegal && !busy && !done, scalar && dst == kr ? "R5 rejected" : "R4 rejected",
          {illegal, busy, done}, 3'b100);
      return;
    end
    chk(!illegal, "R4/R5 accepted", illegal, 0);
    if (vs >= vl) begin
      chk(done && !busy && !out_valid, "R8 empty range", {done, busy, out_valid}, 3'b100);
      return;
    end
    chk(busy && !done, "R6 busy after start", {busy, done}, 2'b10);
    n = (vl - vs) / 4;
    sent = 0; rcvd = 0; cyc = 0;
    acc_prev = 0; held_prev = 0; held = '0;
    st = rnd128(); kg = rnd128();
    while (rcvd < n && cyc < 3000) begin
      out_ready = stall ? ((cyc % 3) != 1) : 1'b1;
      in_valid  = (sent < n);
      in_state  = st;
      in_key    = kg;
      if (poke && cyc == 1) begin
        cmd_start = 1'b1; cmd_sew = 3'b000; cmd_key = rnd128();
      end
      #1;
      if (acc_prev) chk(out_valid, "R10 one-cycle latency", out_valid, 1);
      if (held_prev) chk(out_valid && out_state == held, "R7 hold under stall", out_state, held);
      chk(!illegal && !done, "R9 no reaction while busy", {illegal, done}, 0);
      held_prev = out_valid && !out_ready;
      held = out_state;
      if (out_valid && out_ready) begin
        chk(out_state == expq[0], scalar ? "R1/R3 scalar result" : "R1/R2 per-group result",
            out_state, expq[0]);
        eg = grpq[0];
        chk(out_group == GRP_W'(eg), "R6 group tag", out_group, eg);
        void'(expq.pop_front());
        void'(grpq.pop_front());
        rcvd++;
      end
      acc_prev = in_valid && in_ready;
      if (acc_prev) begin
        expq.push_back(b_quad(st, scalar ? ckey : kg));
        grpq.push_back(vs / 4 + sent);
        sent++;
        st = rnd128(); kg = rnd128();
      end
      @(negedge clk);
      cmd_start = 1'b0;
      cyc++;
    end
    in_valid = 1'b0;
    chk(rcvd == n && sent == n, "R6 group count", sent, n);
    chk(done && !busy && !out_valid && !in_ready, "R8 done after last beat",
        {done, busy, out_valid, in_ready}, 4'b1000);
    @(negedge clk);
    chk(!done && !busy, "R8 single pulse", {done, busy}, 0);
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) sb_tab[i] = b_aff(b_inv(b_aff(8'(i))));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !illegal && !out_valid && !in_ready, "R7/R8 reset state",
        {busy, done, illegal, out_valid, in_ready}, 0);
    rst_n = 1'b1;
    // alignment / length sweep in both key modes
    for (int m = 0; m < 2; m++)
      for (int vs = 0; vs < 8; vs++)
        for (int vl = 0; vl <= 12; vl++)
          run_cmd(m[0], 3'b010, vs, vl, 1, 2, 0, 0);
    // element width codes
    for (int s = 0; s < 8; s++)
      if (s != 2) run_cmd(0, 3'(s), 0, 8, 1, 2, 0, 0);
    // register overlap
    run_cmd(1, 3'b010, 0, 8, 5, 5, 0, 0);
    run_cmd(0, 3'b010, 0, 8, 5, 5, 0, 0);
    // back-pressure in both modes
    run_cmd(0, 3'b010, 0, 32, 1, 2, 1, 0);
    run_cmd(1, 3'b010, 4, 40, 3, 4, 1, 0);
    // start during a run
    run_cmd(0, 3'b010, 4, 20, 1, 2, 0, 1);
    run_cmd(1, 3'b010, 0, 16, 1, 2, 1, 1);
    // largest range
    run_cmd(1, 3'b010, 0, 252, 1, 2, 0, 0);
    run_cmd(0, 3'b010, 240, 252, 1, 2, 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule